// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a 16-bit processor core that can also run in an 8-bit compatible mode. It also keeps the mode bit, which lives outside the status word. Each cycle the block accepts a number of update sources:

- per-flag results from the ALU;
- decoded single-flag set and clear commands;
- a masked bulk set or bulk clear;
- a carry/mode exchange;
- a whole-word load from a stack pull.

When several sources are active in the same cycle, only the one with the highest priority takes effect.

The block drives the status word, the mode bit and the accumulator-width and index-width selects. It also evaluates a 4-bit branch condition against the stored flags and reports whether the branch is taken.

The mode is held by a two-state machine. The states are `MODE_NATIVE` (16-bit capable) and `MODE_EMUL` (8-bit compatible). There are two transitions, and both need an exchange command that is not overridden by a pull:

- `MODE_NATIVE -> MODE_EMUL` is taken when the current carry is 1.
- `MODE_EMUL -> MODE_NATIVE` is taken when the current carry is 0.

In every other case the machine stays in its state. Reset enters `MODE_EMUL`.

While the block is in emulation, status bits 5 and 4 stay at 1. This pins both widths at 8 bits. In native mode the same bits are the accumulator-width flag (bit 5) and the index-width flag (bit 4).

Top module: `status_flags`

## Requirements
- R1: After reset the status word is 0x34 (I, bit 5 and bit 4 set; all other bits 0), `emu_mode` is 1, and both width selects read 1.
- R2: Status bit positions are C=0, Z=1, I=2, D=3, bit 4 = index width, bit 5 = accumulator width, V=6, N=7. `acc_8bit` follows bit 5 and `idx_8bit` follows bit 4, where 1 means 8-bit and 0 means 16-bit.
- R3: `flag_cmd` encodings: 0 none, 1 clear C, 2 clear D, 3 clear I, 4 clear V, 5 set C, 6 set D, 7 set I. Each command alters only its own bit.
- R4: `bulk_cmd` encodings: 1 clears every status bit whose `bulk_mask` bit is 1, and 2 sets every such bit. Codes 0 and 3 do nothing and do not count as active.
- R5: An exchange (`xce_cmd`) swaps C and the mode bit in a single cycle. Entering emulation this way forces bits 5 and 4 to 1.
- R6: While `emu_mode` is 1, status bits 5 and 4 remain 1 regardless of any source.
- R7: A pull (`pull_en`) loads the whole word from `pull_val` (subject to R6) and leaves the mode bit unchanged.
- R8: With no other source active, each status bit whose `alu_we` bit is 1 takes the matching `alu_flags` bit, and all other bits hold.
- R9: Priority among simultaneous sources is pull, then exchange, then bulk, then single-flag, then ALU. Lower sources in that cycle are ignored.
- R10: `br_cond[3:1]` selects the flag: 0 = N, 1 = V, 2 = Z, 3 = C. The branch is taken when that flag equals `br_cond[0]`. Select 4 is taken unconditionally.
- R11: Condition selects 5, 6 and 7 are never taken.
- R12: The mode bit changes only through an exchange that is not overridden by a pull.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_flags | input | 8 | Flag values from the ALU |
| alu_we | input | 8 | Per-bit write enables for `alu_flags` |
| flag_cmd | input | 3 | Single-flag set/clear command |
| bulk_cmd | input | 2 | Masked bulk command |
| bulk_mask | input | 8 | Bit mask for the bulk command |
| xce_cmd | input | 1 | Carry/mode exchange |
| pull_en | input | 1 | Whole-word load from the stack |
| pull_val | input | 8 | Value to load on a pull |
| br_cond | input | 4 | Branch condition code |
| status | output | 8 | Stored status word |
| emu_mode | output | 1 | Mode bit (1 = emulation) |
| acc_8bit | output | 1 | Accumulator width select (1 = 8-bit) |
| idx_8bit | output | 1 | Index width select (1 = 8-bit) |
| br_taken | output | 1 | Branch decision for `br_cond` |

## Verification
Every update source writes a register, so `status`, `emu_mode` and both width selects change at the first rising edge after the command is presented. The bench drives each command 1 ns after an edge, waits for the next rising edge, and samples 1 ns later. `br_taken` is purely combinational from the stored word and the current `br_cond`. It is therefore checked 1 ns after the condition code changes, with no extra clock edge. Priority and emulation-lock cases stack several sources into one cycle and compare the single resulting word against the value the winning source alone would give.

// File: rtl/stf_pkg.sv
package stf_pkg;
    localparam int STAT_W   = 8;
    localparam int COND_W   = 4;
    localparam int BIT_C    = 0;
    localparam int BIT_Z    = 1;
    localparam int BIT_I    = 2;
    localparam int BIT_D    = 3;
    localparam int BIT_XW   = 4;
    localparam int BIT_MW   = 5;
    localparam int BIT_V    = 6;
    localparam int BIT_N    = 7;
    localparam logic [STAT_W-1:0] STAT_RESET = (STAT_W'(1) << BIT_I)
                                             | (STAT_W'(1) << BIT_XW)
                                             | (STAT_W'(1) << BIT_MW);

    typedef enum logic [1:0] {
        MODE_NATIVE = 2'd0,
        MODE_EMUL   = 2'd1
    } mode_e;

    typedef enum logic [1:0] {
        BULK_NONE = 2'd0,
        BULK_CLR  = 2'd1,
        BULK_SET  = 2'd2,
        BULK_RSVD = 2'd3
    } bulk_e;

    typedef enum logic [2:0] {
        ONE_NONE  = 3'd0,
        ONE_CLR_C = 3'd1,
        ONE_CLR_D = 3'd2,
        ONE_CLR_I = 3'd3,
        ONE_CLR_V = 3'd4,
        ONE_SET_C = 3'd5,
        ONE_SET_D = 3'd6,
        ONE_SET_I = 3'd7
    } one_e;

    typedef enum logic [2:0] {
        SEL_N      = 3'd0,
        SEL_V      = 3'd1,
        SEL_Z      = 3'd2,
        SEL_C      = 3'd3,
        SEL_ALWAYS = 3'd4,
        SEL_R5     = 3'd5,
        SEL_R6     = 3'd6,
        SEL_R7     = 3'd7
    } csel_e;
endpackage

// File: rtl/stf_mode_fsm.sv
module stf_mode_fsm
    import stf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xce_fire,
    input  logic carry_now,
    output logic emu_now,
    output logic emu_next
);
    mode_e state_q;
    mode_e state_d;

    // Next-state selection (R5, R12)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NATIVE: if (xce_fire && carry_now)  state_d = MODE_EMUL;
            MODE_EMUL:   if (xce_fire && !carry_now) state_d = MODE_NATIVE;
            default:     state_d = MODE_EMUL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_EMUL;
        else        state_q <= state_d;
    end

    always_comb begin
        emu_now  = (state_q == MODE_EMUL);
        emu_next = (state_d == MODE_EMUL);
    end
endmodule

// File: rtl/stf_flag_path.sv
module stf_flag_path
    import stf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pull_en,
    input  logic [STAT_W-1:0] pull_val,
    input  logic              xce_fire,
    input  logic              emu_now,
    input  logic              emu_next,
    input  logic [1:0]        bulk_cmd,
    input  logic [STAT_W-1:0] bulk_mask,
    input  logic [2:0]        flag_cmd,
    input  logic [STAT_W-1:0] alu_we,
    input  logic [STAT_W-1:0] alu_flags,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] stat_d;
    bulk_e             bulk;
    one_e              one;
    logic              bulk_act;

    always_comb begin
        bulk     = bulk_e'(bulk_cmd);
        one      = one_e'(flag_cmd);
        bulk_act = (bulk == BULK_CLR) || (bulk == BULK_SET);
    end

    // Single-winner update chain (R9)
    always_comb begin
        stat_d = stat_q;
        if (pull_en) begin
            stat_d = pull_val;                          // R7
        end else if (xce_fire) begin
            stat_d[BIT_C] = emu_now;                    // R5
        end else if (bulk_act) begin
            if (bulk == BULK_CLR) stat_d = stat_q & ~bulk_mask;   // R4
            else                  stat_d = stat_q |  bulk_mask;
        end else if (one != ONE_NONE) begin
            unique case (one)                           // R3
                ONE_CLR_C: stat_d[BIT_C] = 1'b0;
                ONE_CLR_D: stat_d[BIT_D] = 1'b0;
                ONE_CLR_I: stat_d[BIT_I] = 1'b0;
                ONE_CLR_V: stat_d[BIT_V] = 1'b0;
                ONE_SET_C: stat_d[BIT_C] = 1'b1;
                ONE_SET_D: stat_d[BIT_D] = 1'b1;
                ONE_SET_I: stat_d[BIT_I] = 1'b1;
                default:   stat_d = stat_q;
            endcase
        end else begin
            stat_d = (stat_q & ~alu_we) | (alu_flags & alu_we);   // R8
        end
        if (emu_next) begin                             // R6
            stat_d[BIT_MW] = 1'b1;
            stat_d[BIT_XW] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= STAT_RESET;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/stf_branch_eval.sv
module stf_branch_eval
    import stf_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    input  logic [COND_W-1:0] cond,
    output logic              taken
);
    csel_e sel;
    logic  pol;

    always_comb begin
        sel   = csel_e'(cond[COND_W-1:1]);
        pol   = cond[0];
        taken = 1'b0;
        unique case (sel)                              // R10, R11
            SEL_N:      taken = (stat[BIT_N] == pol);
            SEL_V:      taken = (stat[BIT_V] == pol);
            SEL_Z:      taken = (stat[BIT_Z] == pol);
            SEL_C:      taken = (stat[BIT_C] == pol);
            SEL_ALWAYS: taken = 1'b1;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/status_flags.sv
module status_flags
    import stf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] alu_flags,
    input  logic [STAT_W-1:0] alu_we,
    input  logic [2:0]        flag_cmd,
    input  logic [1:0]        bulk_cmd,
    input  logic [STAT_W-1:0] bulk_mask,
    input  logic              xce_cmd,
    input  logic              pull_en,
    input  logic [STAT_W-1:0] pull_val,
    input  logic [COND_W-1:0] br_cond,
    output logic [STAT_W-1:0] status,
    output logic              emu_mode,
    output logic              acc_8bit,
    output logic              idx_8bit,
    output logic              br_taken
);
    logic              xce_fire;
    logic              emu_now;
    logic              emu_next;
    logic [STAT_W-1:0] stat_q;

    assign xce_fire = xce_cmd && !pull_en;

    stf_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .xce_fire  (xce_fire),
        .carry_now (stat_q[BIT_C]),
        .emu_now   (emu_now),
        .emu_next  (emu_next)
    );

    stf_flag_path u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .pull_en   (pull_en),
        .pull_val  (pull_val),
        .xce_fire  (xce_fire),
        .emu_now   (emu_now),
        .emu_next  (emu_next),
        .bulk_cmd  (bulk_cmd),
        .bulk_mask (bulk_mask),
        .flag_cmd  (flag_cmd),
        .alu_we    (alu_we),
        .alu_flags (alu_flags),
        .stat_q    (stat_q)
    );

    stf_branch_eval u_branch (
        .stat  (stat_q),
        .cond  (br_cond),
        .taken (br_taken)
    );

    // R2: width selects
    assign status   = stat_q;
    assign emu_mode = emu_now;
    assign acc_8bit = stat_q[BIT_MW];
    assign idx_8bit = stat_q[BIT_XW];
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bulk_cmd,
    input logic [7:0] bulk_mask,
    input logic       xce_cmd,
    input logic       pull_en,
    input logic [7:0] pull_val,
    input logic [3:0] br_cond,
    input logic [7:0] status,
    input logic       emu_mode,
    input logic       br_taken
);
    // R6
    emu_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode |-> (status[5:4] == 2'b11));

    // R5
    xce_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xce_cmd && !pull_en) |=> ((emu_mode == $past(status[0])) && (status[0] == $past(emu_mode))));

    // R7
    pull_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_en |=> ((status[7:6] == $past(pull_val[7:6])) && (status[3:0] == $past(pull_val[3:0])) && $stable(emu_mode)));

    // R4
    bulk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pull_en && !xce_cmd && bulk_cmd == 2'b10) |=> ((status & $past(bulk_mask)) == $past(bulk_mask)));

    // R10
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_cond[3:1] == 3'b100) |-> br_taken);

    // R11
    never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_cond[3:1] > 3'b100) |-> !br_taken);

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xce_cmd || pull_en) |=> $stable(emu_mode));
endmodule

bind status_flags status_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bulk_cmd  (bulk_cmd),
    .bulk_mask (bulk_mask),
    .xce_cmd   (xce_cmd),
    .pull_en   (pull_en),
    .pull_val  (pull_val),
    .br_cond   (br_cond),
    .status    (status),
    .emu_mode  (emu_mode),
    .br_taken  (br_taken)
);

// File: tb/status_flags_bench.sv
module status_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] alu_flags, alu_we, bulk_mask, pull_val, status;
    logic [2:0] flag_cmd;
    logic [1:0] bulk_cmd;
    logic [3:0] br_cond;
    logic       xce_cmd, pull_en, emu_mode, acc_8bit, idx_8bit, br_taken;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    status_flags u_status_flags (
        .clk(clk), .rst_n(rst_n), .alu_flags(alu_flags), .alu_we(alu_we),
        .flag_cmd(flag_cmd), .bulk_cmd(bulk_cmd), .bulk_mask(bulk_mask),
        .xce_cmd(xce_cmd), .pull_en(pull_en), .pull_val(pull_val),
        .br_cond(br_cond), .status(status), .emu_mode(emu_mode),
        .acc_8bit(acc_8bit), .idx_8bit(idx_8bit), .br_taken(br_taken)
    );

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic idle();
        alu_flags = 8'h00; alu_we = 8'h00; flag_cmd = 3'd0; bulk_cmd = 2'd0;
        bulk_mask = 8'h00; xce_cmd = 1'b0; pull_en = 1'b0; pull_val = 8'h00;
    endtask

    // one clock: inputs already set 1 ns after an edge; sample 1 ns after the next edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic step_chk(input string rq, input logic [7:0] exp_s, input logic exp_e);
        tick();
        check(rq, {8'h0, status}, {8'h0, exp_s});
        check(rq, {15'h0, emu_mode}, {15'h0, exp_e});
        idle();
    endtask

    task automatic br_sweep(input string rq, input logic [15:0] exp_vec);
        logic [15:0] got;
        for (int c = 0; c < 16; c++) begin
            br_cond = 4'(c);
            #1;
            got[c] = br_taken;
        end
        check(rq, got, exp_vec);
        br_cond = 4'd0;
    endtask

    task automatic t_reset();
        check("R1 status", {8'h0, status}, 16'h0034);
        check("R1 emu", {15'h0, emu_mode}, 16'h1);
        check("R1 widths", {14'h0, acc_8bit, idx_8bit}, 16'h3);
    endtask

    task automatic t_native();
        xce_cmd = 1'b1;                step_chk("R5 enter native", 8'h35, 1'b0);
        bulk_cmd = 2'd1; bulk_mask = 8'h30; step_chk("R4 bulk clear", 8'h05, 1'b0);
        check("R2 widths 16-bit", {14'h0, acc_8bit, idx_8bit}, 16'h0);
        bulk_cmd = 2'd3; bulk_mask = 8'hFF; step_chk("R4 reserved code", 8'h05, 1'b0);
    endtask

    task automatic t_single();
        flag_cmd = 3'd1; step_chk("R3 clear C", 8'h04, 1'b0);
        flag_cmd = 3'd3; step_chk("R3 clear I", 8'h00, 1'b0);
        flag_cmd = 3'd6; step_chk("R3 set D", 8'h08, 1'b0);
        flag_cmd = 3'd7; step_chk("R3 set I", 8'h0C, 1'b0);
        flag_cmd = 3'd2; step_chk("R3 clear D", 8'h04, 1'b0);
        flag_cmd = 3'd5; step_chk("R3 set C", 8'h05, 1'b0);
        alu_we = 8'h40; alu_flags = 8'h40; step_chk("R8 set V", 8'h45, 1'b0);
        flag_cmd = 3'd4; step_chk("R3 clear V", 8'h05, 1'b0);
        bulk_cmd = 2'd2; bulk_mask = 8'h30; step_chk("R4 bulk set", 8'h35, 1'b0);
        check("R2 widths 8-bit", {14'h0, acc_8bit, idx_8bit}, 16'h3);
        bulk_cmd = 2'd1; bulk_mask = 8'h20; step_chk("R4 bulk clear one", 8'h15, 1'b0);
        check("R2 acc 16 idx 8", {14'h0, acc_8bit, idx_8bit}, 16'h1);
        bulk_cmd = 2'd1; bulk_mask = 8'h10; step_chk("R4 bulk clear idx", 8'h05, 1'b0);
    endtask

    task automatic t_alu();
        alu_we = 8'hC2; alu_flags = 8'hFF; step_chk("R8 partial set", 8'hC7, 1'b0);
        alu_we = 8'h03; alu_flags = 8'h00; step_chk("R8 partial clear", 8'hC4, 1'b0);
        alu_we = 8'h00; alu_flags = 8'hFF; step_chk("R8 no enable", 8'hC4, 1'b0);
    endtask

    task automatic t_branch();
        // status 0xC4: N=1 V=1 Z=0 C=0
        br_sweep("R10 R11 sweep at C4", 16'h035A);
    endtask

    task automatic t_priority();
        pull_en = 1'b1; pull_val = 8'h00; xce_cmd = 1'b1; bulk_cmd = 2'd2;
        bulk_mask = 8'hFF; flag_cmd = 3'd5; alu_we = 8'hFF; alu_flags = 8'hFF;
        step_chk("R9 pull wins", 8'h00, 1'b0);
        br_sweep("R10 sweep at 00", 16'h0355);
        flag_cmd = 3'd5; step_chk("R3 set C again", 8'h01, 1'b0);
        xce_cmd = 1'b1; bulk_cmd = 2'd2; bulk_mask = 8'hFF; alu_we = 8'hFF; alu_flags = 8'hFF;
        step_chk("R9 R5 exchange wins", 8'h30, 1'b1);
        bulk_cmd = 2'd1; bulk_mask = 8'h31; flag_cmd = 3'd5; alu_we = 8'hFF; alu_flags = 8'hFF;
        step_chk("R9 R6 bulk wins", 8'h30, 1'b1);
        flag_cmd = 3'd6; alu_we = 8'h80; alu_flags = 8'h80;
        step_chk("R9 single wins", 8'h38, 1'b1);
        alu_we = 8'h80; alu_flags = 8'h80; step_chk("R9 alu alone", 8'hB8, 1'b1);
    endtask

    task automatic t_emul_lock();
        pull_en = 1'b1; pull_val = 8'h00; step_chk("R6 R7 pull in emul", 8'h30, 1'b1);
        check("R6 widths", {14'h0, acc_8bit, idx_8bit}, 16'h3);
        bulk_cmd = 2'd1; bulk_mask = 8'hFF; step_chk("R6 bulk clear in emul", 8'h30, 1'b1);
        alu_we = 8'h30; alu_flags = 8'h00; step_chk("R6 alu in emul", 8'h30, 1'b1);
        xce_cmd = 1'b1; step_chk("R5 leave emul", 8'h31, 1'b0);
        pull_en = 1'b1; pull_val = 8'h00; xce_cmd = 1'b1;
        step_chk("R12 pull blocks exchange", 8'h00, 1'b0);
        pull_en = 1'b1; pull_val = 8'hFF; step_chk("R7 pull native", 8'hFF, 1'b0);
        check("R2 pulled widths", {14'h0, acc_8bit, idx_8bit}, 16'h3);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        br_cond = 4'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_native();
        t_single();
        t_alu();
        t_branch();
        t_priority();
        t_emul_lock();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule